// File: doc/BRIEF.md
# Selectable-Layout 16-bit Pixel Unpacker

This block turns a stream of 32-bit framebuffer words into a stream of 24-bit RGB pixels, two pixels per word. Each half of a word is one 16-bit pixel. A 2-bit side-band layout select picks how the three colour fields sit inside the 16 bits: 5-5-5 with one spare bit, 5-6-5 with red in the top field, or 5-6-5 with blue in the top field. A red/blue exchange bit from the display control logic is obeyed by some layout codes and ignored by one. A half-order bit picks which half of each word is shown first.

Both sides use a valid/ready handshake. The layout select, the exchange bit and the half-order bit are captured together with the word when it is accepted. Changing them while a word is being unpacked therefore never splits that word. Output backpressure holds the current pixel and stops new words from being accepted. No pixel is dropped and pixel order is kept.

Top module: `px16_unpack`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `hi_first`=0 the pixel in bits 15:0 of a word is sent first and the pixel in bits 31:16 second. With `hi_first`=1 the order is reversed.
- R3: Layout code 2 with `swap_rb`=0 decodes red from bits 15:11, green from 10:5 and blue from 4:0. `out_rgb` is {red[23:16], green[15:8], blue[7:0]}.
- R4: Layout code 0 decodes exactly as code 2, for both values of `swap_rb`.
- R5: Layout code 3 decodes blue from bits 15:11, green from 10:5 and red from 4:0, whatever the value of `swap_rb`.
- R6: Layout code 1 decodes red from bits 14:10, green from 9:5 and blue from 4:0. Bit 15 has no effect on the output.
- R7: For layout codes 0, 1 and 2, `swap_rb`=1 exchanges the red and blue output channels after widening.
- R8: A 5-bit field v widens to {v, v[4:2]}. A 6-bit field v widens to {v, v[5:4]}.
- R9: `layout_sel`, `swap_rb` and `hi_first` are captured when a word is accepted. Changing them afterwards has no effect on that word's two pixels.
- R10: While `out_valid`=1 and `out_ready`=0, `out_rgb` holds its value and `in_ready` is 0. Every pixel is delivered once, in order.
- R11: With `out_ready` held at 1 and input words always offered, one pixel leaves per cycle with no gap between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word accepted when both valid and ready are high |
| in_word | input | 32 | Two packed 16-bit pixels |
| layout_sel | input | 2 | 16-bit layout code (0..3) |
| swap_rb | input | 1 | Red/blue exchange request |
| hi_first | input | 1 | 1: upper half of the word is the first pixel |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Sink takes the pixel |
| out_rgb | output | 24 | {red, green, blue}, 8 bits each |

## Verification
The captured word, its captured controls and the half index are the only state in the block. A wrong control capture shows up as a wrong colour on the very next output pixel, even if the live controls have been changed. A wrong half index shows as swapped or repeated pixels within two output handshakes. A wrong full flag shows as a lost or duplicated pixel, or as `in_ready` rising while a stalled pixel is still waiting. All of these appear within one word's lifetime. Stalls are held several cycles so that the held output and the blocked input can be checked together.

// File: rtl/px16_pkg.sv
package px16_pkg;
  localparam int PIX_W = 16;
  localparam int CH_W  = 8;

  typedef enum logic [1:0] {
    LAY_DEFAULT = 2'd0,
    LAY_5551    = 2'd1,
    LAY_565_RHI = 2'd2,
    LAY_565_BHI = 2'd3
  } layout_e;

  typedef struct packed {
    logic [1:0] layout;
    logic       swap;
    logic       hi_first;
  } ctrl_t;
endpackage

// File: rtl/px16_rst_sync.sv
module px16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/px16_widen.sv
module px16_widen #(
  parameter int IN_W  = 5,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  field,
  output logic [OUT_W-1:0] wide
);
  localparam int FILL_W = OUT_W - IN_W;

  generate
    if (FILL_W <= 0) begin : g_trunc
      assign wide = field[IN_W-1 -: OUT_W];
    end else if (FILL_W <= IN_W) begin : g_rep
      // low bits are filled from the field's most significant bits (R8)
      assign wide = {field, field[IN_W-1 -: FILL_W]};
    end else begin : g_zero
      assign wide = {field, {FILL_W{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/px16_decode.sv
module px16_decode
  import px16_pkg::*;
#(
  parameter int CW = CH_W
) (
  input  logic [PIX_W-1:0] pix,
  input  ctrl_t            ctrl,
  output logic [3*CW-1:0]  rgb
);
  logic [CW-1:0] top5_w, mid6_w, low5_w, hi5_w, mid5_w;
  logic [CW-1:0] red_raw, grn_raw, blu_raw;
  logic          honour_swap;

  px16_widen #(.IN_W(5), .OUT_W(CW)) u_top5 (.field(pix[15:11]), .wide(top5_w));
  px16_widen #(.IN_W(6), .OUT_W(CW)) u_mid6 (.field(pix[10:5]),  .wide(mid6_w));
  px16_widen #(.IN_W(5), .OUT_W(CW)) u_low5 (.field(pix[4:0]),   .wide(low5_w));
  px16_widen #(.IN_W(5), .OUT_W(CW)) u_hi5  (.field(pix[14:10]), .wide(hi5_w));
  px16_widen #(.IN_W(5), .OUT_W(CW)) u_mid5 (.field(pix[9:5]),   .wide(mid5_w));

  always_comb begin
    red_raw     = top5_w;
    grn_raw     = mid6_w;
    blu_raw     = low5_w;
    honour_swap = 1'b1;
    unique case (layout_e'(ctrl.layout))
      LAY_5551: begin
        red_raw = hi5_w;
        grn_raw = mid5_w;
        blu_raw = low5_w;
      end
      LAY_565_BHI: begin
        red_raw     = low5_w;
        grn_raw     = mid6_w;
        blu_raw     = top5_w;
        honour_swap = 1'b0;
      end
      default: begin
        red_raw = top5_w;
        grn_raw = mid6_w;
        blu_raw = low5_w;
      end
    endcase
  end

  always_comb begin
    if (honour_swap && ctrl.swap) rgb = {blu_raw, grn_raw, red_raw};
    else                          rgb = {red_raw, grn_raw, blu_raw};
  end

  // a_r5_bhi_no_swap: code 3 always puts the top field in the blue channel
  always_comb begin
    if (ctrl.layout == 2'd3) begin
      a_r5_bhi_no_swap: assert (rgb[CW-1:0] == top5_w)
        else $error("a_r5_bhi_no_swap");
    end
  end
endmodule

// File: rtl/px16_unpack.sv
module px16_unpack
  import px16_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [1:0]        layout_sel,
  input  logic              swap_rb,
  input  logic              hi_first,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3*CH_W-1:0] out_rgb
);
  localparam int NPIX  = WORD_W / PIX_W;
  localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);

  logic rst_s_n;
  px16_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  // state
  logic [WORD_W-1:0] word_q, word_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              full_q, full_d;
  logic              load_en, idx_en;

  logic              in_fire, out_fire, last_pix;
  logic [PIX_W-1:0]  pix_arr [NPIX];
  logic [IDX_W-1:0]  sel_idx;
  logic [PIX_W-1:0]  cur_pix;

  genvar gi;
  generate
    for (gi = 0; gi < NPIX; gi++) begin : g_split
      assign pix_arr[gi] = word_q[gi*PIX_W +: PIX_W];
    end
  endgenerate

  assign sel_idx  = ctrl_q.hi_first ? (LAST_IDX - idx_q) : idx_q;
  assign cur_pix  = pix_arr[sel_idx];
  assign last_pix = (idx_q == LAST_IDX);

  assign out_valid = full_q;
  assign in_ready  = !full_q || (out_ready && last_pix);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = full_q && out_ready;

  // next-state
  always_comb begin
    word_d  = word_q;
    ctrl_d  = ctrl_q;
    idx_d   = idx_q;
    full_d  = full_q;
    load_en = 1'b0;
    idx_en  = 1'b0;
    if (in_fire) begin
      load_en = 1'b1;
      idx_en  = 1'b1;
      word_d  = in_word;
      ctrl_d  = '{layout: layout_sel, swap: swap_rb, hi_first: hi_first};
      idx_d   = '0;
      full_d  = 1'b1;
    end else if (out_fire) begin
      idx_en = 1'b1;
      if (last_pix) begin
        full_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      full_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      full_q <= full_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      word_q <= '0;
      ctrl_q <= '0;
    end else if (load_en) begin
      word_q <= word_d;
      ctrl_q <= ctrl_d;
    end
  end

  px16_decode #(.CW(CH_W)) u_dec (.pix(cur_pix), .ctrl(ctrl_q), .rgb(out_rgb));

  // assertions
  a_r10_hold_pixel: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)))
    else $error("a_r10_hold_pixel");

  a_r10_block_input: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && !out_ready) |-> !in_ready)
    else $error("a_r10_block_input");

  a_r9_ctrl_held: assert property (@(posedge clk) disable iff (!rst_s_n)
    (full_q && !in_fire) |=> $stable(ctrl_q))
    else $error("a_r9_ctrl_held");

  a_r1_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_s_n)
    !out_valid |-> in_ready)
    else $error("a_r1_ready_when_empty");

  a_r11_refill: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_fire && last_pix && !in_fire) |=> !out_valid)
    else $error("a_r11_refill");
endmodule

// File: tb/px16_unpack_tb_top.sv
`timescale 1ns/100ps
module px16_unpack_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [31:0] in_word;
  logic [1:0]  layout_sel;
  logic        swap_rb, hi_first;
  logic        out_valid, out_ready;
  logic [23:0] out_rgb;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [23:0] got_q[$];
  int          got_t[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  px16_unpack dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .layout_sel(layout_sel), .swap_rb(swap_rb),
    .hi_first(hi_first), .out_valid(out_valid), .out_ready(out_ready),
    .out_rgb(out_rgb));

  // output collector: sampled 1 ns after each falling edge
  always begin
    @(negedge clk); #1;
    if (rst_n && out_valid && out_ready) begin
      got_q.push_back(out_rgb);
      got_t.push_back(cyc);
    end
  end

  function automatic logic [7:0] w5(input logic [4:0] v); return {v, v[4:2]}; endfunction
  function automatic logic [7:0] w6(input logic [5:0] v); return {v, v[5:4]}; endfunction

  function automatic logic [23:0] model(input logic [15:0] p, input logic [1:0] code, input logic sw);
    logic [7:0] r, g, b;
    case (code)
      2'd1:    begin r = w5(p[14:10]); g = w5(p[9:5]);  b = w5(p[4:0]);   end
      2'd3:    begin r = w5(p[4:0]);   g = w6(p[10:5]); b = w5(p[15:11]); end
      default: begin r = w5(p[15:11]); g = w6(p[10:5]); b = w5(p[4:0]);   end
    endcase
    if (sw && code != 2'd3) return {b, g, r};
    return {r, g, b};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic [1:0] c, input logic s, input logic h);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; layout_sel = c; swap_rb = s; hi_first = h;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    repeat (n) @(negedge clk);
    #1.5;
  endtask

  task automatic expect_word(input string req, input logic [31:0] w,
                             input logic [1:0] c, input logic s, input logic h);
    logic [15:0] first_p, second_p;
    first_p  = h ? w[31:16] : w[15:0];
    second_p = h ? w[15:0]  : w[31:16];
    if (got_q.size() < 2) begin
      chk({req, " count"}, got_q.size(), 2);
    end else begin
      chk({req, " pix0"}, {8'h0, got_q.pop_front()}, {8'h0, model(first_p, c, s)});
      chk({req, " pix1"}, {8'h0, got_q.pop_front()}, {8'h0, model(second_p, c, s)});
      void'(got_t.pop_front()); void'(got_t.pop_front());
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_format(input string req, input logic [31:0] w,
                          input logic [1:0] c, input logic s, input logic h);
    out_ready = 1'b1;
    send(w, c, s, h);
    drain(4);
    expect_word(req, w, c, s, h);
  endtask

  task automatic t_fixed();
    // R3/R8: pure red top field, full white and zero
    out_ready = 1'b1;
    send(32'hFFFF_F800, 2'd2, 1'b0, 1'b0);
    drain(4);
    chk("R3 red", {8'h0, got_q.pop_front()}, 32'h00FF0000);
    chk("R8 white", {8'h0, got_q.pop_front()}, 32'h00FFFFFF);
    void'(got_t.pop_front()); void'(got_t.pop_front());
    // R6: bit 15 ignored in 5551
    send(32'h0000_8000, 2'd1, 1'b0, 1'b0);
    drain(4);
    chk("R6 bit15", {8'h0, got_q.pop_front()}, 32'h0);
    chk("R6 zero", {8'h0, got_q.pop_front()}, 32'h0);
    void'(got_t.pop_front()); void'(got_t.pop_front());
    // R8: 5-bit 10000b -> 10000100b in green of 5551
    send(32'h0000_0200, 2'd1, 1'b0, 1'b0);
    drain(4);
    chk("R8 widen5", {8'h0, got_q.pop_front()}, 32'h00008400);
    void'(got_q.pop_front());
    void'(got_t.pop_front()); void'(got_t.pop_front());
  endtask

  task automatic t_stall();
    logic [31:0] w1, w2;
    w1 = 32'h1234_A5C3; w2 = 32'h0F0F_7E81;
    out_ready = 1'b0;
    send(w1, 2'd2, 1'b1, 1'b1);
    // controls change after capture (R9)
    layout_sel = 2'd1; swap_rb = 1'b0; hi_first = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 valid held", out_valid, 1);
    chk("R10 in_ready low", in_ready, 0);
    chk("R9 first pixel", {8'h0, out_rgb}, {8'h0, model(w1[31:16], 2'd2, 1'b1)});
    fork
      send(w2, 2'd3, 1'b1, 1'b0);
      begin
        repeat (4) @(negedge clk);
        #1;
        chk("R10 still blocked", in_ready, 0);
        chk("R10 rgb stable", {8'h0, out_rgb}, {8'h0, model(w1[31:16], 2'd2, 1'b1)});
        @(negedge clk);
        out_ready = 1'b1;
      end
    join
    drain(4);
    expect_word("R9/R10 w1", w1, 2'd2, 1'b1, 1'b1);
    expect_word("R5/R10 w2", w2, 2'd3, 1'b1, 1'b0);
  endtask

  task automatic t_stream();
    int t0;
    out_ready = 1'b1;
    got_q.delete(); got_t.delete();
    @(negedge clk);
    in_valid = 1'b1; in_word = 32'h1111_2222; layout_sel = 2'd0; swap_rb = 1'b0; hi_first = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      in_word = in_word + 32'h0101_0101;
    end
    in_valid = 1'b0;
    drain(4);
    chk("R11 count", got_q.size(), 8);
    if (got_t.size() == 8) begin
      t0 = got_t[0];
      chk("R11 span", got_t[7] - t0, 7);
    end
    got_q.delete(); got_t.delete();
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; layout_sel = '0;
    swap_rb = 1'b0; hi_first = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fixed();
    t_format("R2/R3 lo-first", 32'hA5C3_3C5A, 2'd2, 1'b0, 1'b0);
    t_format("R2 hi-first",    32'hA5C3_3C5A, 2'd2, 1'b0, 1'b1);
    t_format("R4 code0",       32'h7BEF_8421, 2'd0, 1'b0, 1'b0);
    t_format("R4/R7 code0 sw", 32'h7BEF_8421, 2'd0, 1'b1, 1'b0);
    t_format("R5 code3",       32'hF81F_07E0, 2'd3, 1'b0, 1'b0);
    t_format("R5 code3 sw",    32'hF81F_07E0, 2'd3, 1'b1, 1'b1);
    t_format("R6 5551",        32'hFC00_83E0, 2'd1, 1'b0, 1'b0);
    t_format("R7 5551 sw",     32'hFC00_83E0, 2'd1, 1'b1, 1'b0);
    t_format("R7 code2 sw",    32'hF800_001F, 2'd2, 1'b1, 1'b0);
    t_stall();
    t_stream();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule